// File: doc/BRIEF.md
# Configuration Status Register with Interrupt Gating

This block holds the 16-bit status word of one function of a bus target device, located at byte offset 06h of that function's configuration space. Three bits are sticky error flags. Hardware event strobes set them, and the host clears them by writing ones. The flags record a parity error (address or data), a system error that was signaled while reporting was enabled, and a target abort that the device issued. The device-select timing field and the capabilities-present bit are fixed constants. Every other bit outside the flags and the interrupt bit reads zero.

Bit 3 is a live interrupt status. Each clock it registers whether an interrupt condition exists and signaling of that condition is enabled. An external interrupt-disable control masks the active-low interrupt output without changing bit 3. The output comes from a flop, so it cannot glitch.

Configuration access is plain control. A write strobe, a byte address, two byte enables and write data form the write side. Read data is a combinational view of the register whenever the address selects offset 06h, and zero otherwise. There is no handshake and no back-pressure, because every access completes in one cycle.

Top module: `csr_status_reg`

## Requirements
- R1: After reset, a read at offset 06h returns 0x0210 and `intx_n` is 1.
- R2: Bits 10:9 always read 01b and bit 4 always reads 1. Bits 13, 12, 8, 7, 6, 5 and 2:0 always read 0, even after a write of 0xFFFF with both byte enables set.
- R3: A one-cycle pulse on `ev_addr_par` or on `ev_data_par` sets bit 15 at the next clock edge. The bit stays set until it is cleared.
- R4: A pulse on `ev_serr_sig` sets bit 14 only when `serr_en` is 1 in the same cycle. With `serr_en` at 0, bit 14 stays 0.
- R5: A pulse on `ev_tabort_sig` sets bit 11 at the next clock edge. The bit stays set until it is cleared.
- R6: At offset 06h, writing 1 to bit 15, 14 or 11 clears that bit at the next edge. Writing 0 to any of them leaves it unchanged.
- R7: `cfg_be[1]` enables bits 15:8 and `cfg_be[0]` enables bits 7:0. A write with `cfg_be[1]`=0 leaves bits 15, 14 and 11 unchanged.
- R8: If a set event and a write-one-to-clear hit the same flag in the same cycle, the flag is 1 after that edge.
- R9: At each edge, bit 3 takes the value of `int_cond` AND `int_sig_en` sampled at that edge.
- R10: At each edge, `intx_n` becomes 0 exactly when `int_cond` AND `int_sig_en` AND NOT `int_disable` hold at that edge. `int_disable` has no effect on bit 3.
- R11: A write whose `cfg_addr` is not 06h changes no bit. A read at any address other than 06h returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data, combinational |
| ev_addr_par | input | 1 | Address parity error detected |
| ev_data_par | input | 1 | Data parity error detected |
| ev_serr_sig | input | 1 | System error signaled |
| serr_en | input | 1 | System-error reporting enable |
| ev_tabort_sig | input | 1 | Target abort issued |
| int_cond | input | 1 | Interrupt condition present |
| int_sig_en | input | 1 | Signaling of the interrupt condition enabled |
| int_disable | input | 1 | Interrupt output disable |
| intx_n | output | 1 | Active-low interrupt output, registered |

## Verification
Each parity source is pulsed on its own, so a dropped source in the OR shows up as a missing flag. The system-error strobe is applied with the enable both low and high, which separates gated capture from ungated capture. Clear writes are tried with a selective ones pattern, an all-zero pattern, the upper byte lane disabled and a wrong address, which separates correct write-one-to-clear behaviour from write-through, inverted sense, lane or decode errors. The collision case and the interrupt cases are also covered. In the collision case a set and a clear land on one flag in the same cycle. The interrupt cases step through the combinations of condition, enable and disable, which shows whether the mask acts on the output only or also on the status bit.

// File: rtl/csr_status_pkg.sv
package csr_status_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned NUM_FLAGS = 3;
  localparam logic [ADDR_W-1:0] STATUS_OFFSET = 8'h06;
  // sticky flag positions: parity, system error, target abort
  localparam int unsigned FLAG_POS [NUM_FLAGS] = '{15, 14, 11};
  localparam int unsigned INT_POS  = 3;
  // fixed encodings: timing field 10:9 = 01b, capabilities bit 4 = 1
  localparam logic [DATA_W-1:0] FIXED_VAL = 16'h0210;
endpackage

// File: rtl/csr_w1c_flag.sv
module csr_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= set_i | (flag_o & ~clr_i);
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_acts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/csr_irq_gate.sv
module csr_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic int_cond,
  input  logic int_sig_en,
  input  logic int_disable,
  output logic int_stat,
  output logic intx_n
);
  logic valid_int;
  assign valid_int = int_cond & int_sig_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_stat <= 1'b0;
      intx_n   <= 1'b1;
    end else begin
      int_stat <= valid_int;
      intx_n   <= ~(valid_int & ~int_disable);
    end
  end

  p_intx_needs_stat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !intx_n |-> int_stat);
  p_stat_rise_enabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_stat) |-> $past(int_sig_en));
endmodule

// File: rtl/csr_status_reg.sv
module csr_status_reg
  import csr_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W/8-1:0] cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              ev_addr_par,
  input  logic              ev_data_par,
  input  logic              ev_serr_sig,
  input  logic              serr_en,
  input  logic              ev_tabort_sig,
  input  logic              int_cond,
  input  logic              int_sig_en,
  input  logic              int_disable,
  output logic              intx_n
);
  localparam int unsigned BE_W = DATA_W / 8;

  logic                 hit;
  logic                 wr_hit;
  logic [NUM_FLAGS-1:0] flag_set;
  logic [NUM_FLAGS-1:0] flag_clr;
  logic [NUM_FLAGS-1:0] flag_q;
  logic                 int_stat;
  logic [DATA_W-1:0]    status;

  assign hit    = (cfg_addr == STATUS_OFFSET);
  assign wr_hit = cfg_wr & hit;

  assign flag_set[0] = ev_addr_par | ev_data_par;
  assign flag_set[1] = ev_serr_sig & serr_en;
  assign flag_set[2] = ev_tabort_sig;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    localparam int unsigned POS  = FLAG_POS[i];
    localparam int unsigned LANE = POS / 8;
    assign flag_clr[i] = wr_hit & cfg_be[LANE] & cfg_wdata[POS];
    csr_w1c_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (flag_set[i]),
      .clr_i  (flag_clr[i]),
      .flag_o (flag_q[i])
    );
  end

  csr_irq_gate u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_cond    (int_cond),
    .int_sig_en  (int_sig_en),
    .int_disable (int_disable),
    .int_stat    (int_stat),
    .intx_n      (intx_n)
  );

  always_comb begin
    status = FIXED_VAL;
    for (int i = 0; i < NUM_FLAGS; i++) status[FLAG_POS[i]] = flag_q[i];
    status[INT_POS] = int_stat;
  end

  assign cfg_rdata = hit ? status : '0;

  p_miss_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (cfg_rdata == '0));
  p_fixed_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((cfg_rdata & 16'h37F7) == 16'h0210));
  p_serr_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!serr_en && !flag_q[1]) |=> !flag_q[1]);
  p_lane_off_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_be[BE_W-1] && flag_set == '0) |=> $stable(flag_q));
endmodule

// File: tb/tb_csr_status_reg.sv
module tb_csr_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_addr = 8'h06;
  logic [1:0] cfg_be = 2'b00;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic ev_addr_par = 0, ev_data_par = 0, ev_serr_sig = 0, serr_en = 0, ev_tabort_sig = 0;
  logic int_cond = 0, int_sig_en = 0, int_disable = 0;
  logic intx_n;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  csr_status_reg dut (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [15:0] exp);
    cfg_addr = 8'h06; #1; chk(tag, cfg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [15:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    tick();
    cfg_wr = 0; cfg_addr = 8'h06; cfg_be = 0; cfg_wdata = 0;
  endtask

  task automatic clear_all();
    wr(8'h06, 2'b11, 16'hFFFF);
  endtask

  task automatic t_reset();
    rd("R1 reset value", 16'h0210);
    chk("R1 intx_n reset", {15'd0, intx_n}, 16'd1);
  endtask

  task automatic t_const();
    wr(8'h06, 2'b11, 16'hFFFF);
    rd("R2 fixed fields after FFFF", 16'h0210);
  endtask

  task automatic t_parity();
    ev_addr_par = 1; tick(); ev_addr_par = 0;
    rd("R3 addr parity sets 15", 16'h8210);
    tick(); rd("R3 sticky", 16'h8210);
    clear_all();
    ev_data_par = 1; tick(); ev_data_par = 0;
    rd("R3 data parity sets 15", 16'h8210);
    clear_all();
  endtask

  task automatic t_serr();
    serr_en = 0; ev_serr_sig = 1; tick(); ev_serr_sig = 0;
    rd("R4 serr disabled no set", 16'h0210);
    serr_en = 1; ev_serr_sig = 1; tick(); ev_serr_sig = 0; serr_en = 0;
    rd("R4 serr enabled sets 14", 16'h4210);
    clear_all();
  endtask

  task automatic t_tabort();
    ev_tabort_sig = 1; tick(); ev_tabort_sig = 0;
    rd("R5 tabort sets 11", 16'h0A10);
    clear_all();
  endtask

  task automatic t_w1c();
    ev_addr_par = 1; serr_en = 1; ev_serr_sig = 1; ev_tabort_sig = 1; tick();
    ev_addr_par = 0; serr_en = 0; ev_serr_sig = 0; ev_tabort_sig = 0;
    rd("R6 all flags set", 16'hCA10);
    wr(8'h06, 2'b11, 16'h0000);
    rd("R6 zero write keeps", 16'hCA10);
    wr(8'h06, 2'b11, 16'h4000);
    rd("R6 clear bit14 only", 16'h8A10);
    wr(8'h06, 2'b01, 16'hFFFF);
    rd("R7 upper lane off keeps", 16'h8A10);
    wr(8'h0A, 2'b11, 16'hFFFF);
    rd("R11 wrong addr write ignored", 16'h8A10);
    cfg_addr = 8'h04; #1; chk("R11 wrong addr read zero", cfg_rdata, 16'h0000);
    wr(8'h06, 2'b10, 16'h8800);
    rd("R6 clear 15 and 11", 16'h0210);
  endtask

  task automatic t_collide();
    ev_tabort_sig = 1; cfg_wr = 1; cfg_addr = 8'h06; cfg_be = 2'b11; cfg_wdata = 16'h0800;
    tick();
    ev_tabort_sig = 0; cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
    rd("R8 set wins over clear", 16'h0A10);
    clear_all();
    rd("R8 later clear works", 16'h0210);
  endtask

  task automatic t_irq();
    int_cond = 1; int_sig_en = 0; int_disable = 0; tick();
    rd("R9 cond without enable", 16'h0210);
    chk("R10 intx idle", {15'd0, intx_n}, 16'd1);
    int_sig_en = 1; tick();
    rd("R9 bit3 set", 16'h0218);
    chk("R10 intx asserted", {15'd0, intx_n}, 16'd0);
    int_disable = 1; tick();
    rd("R10 disable keeps bit3", 16'h0218);
    chk("R10 intx masked", {15'd0, intx_n}, 16'd1);
    int_disable = 0; int_cond = 0; tick();
    rd("R9 bit3 cleared", 16'h0210);
    chk("R10 intx released", {15'd0, intx_n}, 16'd1);
    int_sig_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_const();
    t_parity();
    t_serr();
    t_tabort();
    t_w1c();
    t_collide();
    t_irq();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired got=1 exp=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule